// File: doc/BRIEF.md
# Variable-Page Translation Buffer with Access Rights

This block is a small, fully associative translation cache. It maps virtual page numbers to physical page numbers, and every entry carries its own page size. A lookup presents a virtual address, an access kind and the privilege level of the requester. One clock later the block answers with exactly one outcome: a translated physical address, a miss, a protection fault, or a multiple-match error.

Page sizes are powers of four, from 4 KB to 64 MB. For a larger page, more low address bits bypass the tag compare, and those same bits pass straight from the virtual address into the physical address. A page-fill agent loads entries through an insert port, and slots are replaced in turn. A purge input empties the whole table in one cycle.

Top module: `vp_tlb`

## Requirements
- R1: After reset no entry is valid and the response outputs are all zero; the first lookup reports a miss.
- R2: A lookup request sampled on a clock edge produces `rsp_valid` high right after that edge, with exactly one of hit, miss, fault or multi set. A cycle without a request gives `rsp_valid` low and all flags low.
- R3: A lookup for which no valid entry matches reports a miss.
- R4: Size code s (0 to 7) gives a page of 4 KB × 4^s, which is 2^(12+2s) bytes. Virtual address bits below 12+2s are left out of the compare and copied unchanged into the physical address. The bits above come from the stored physical page number.
- R5: The access kind is encoded as 0 for read, 1 for write and 2 for execute, and 3 is handled as execute. Each entry holds a separate required privilege for read, write and execute.
- R6: An access on a matching entry is allowed only when the request privilege (0 = most privileged, 3 = least) is numerically less than or equal to the required level. Otherwise a fault is reported instead of a hit.
- R7: When more than one valid entry matches, only `rsp_multi` is set.
- R8: Inserts fill slots in turn, starting at slot 0 and wrapping after the last slot. An insert affects lookups from the next cycle on; a lookup in the same cycle sees the old contents.
- R9: Purge clears every valid bit and returns the replacement pointer to slot 0 in one cycle. An insert in the same cycle is ignored.
- R10: `rsp_paddr` is zero unless `rsp_hit` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| lk_priv | input | 2 | Requester privilege, 0 most privileged |
| ins_valid | input | 1 | Load an entry into the next slot |
| ins_vpn | input | VA_W-12 | Virtual page number of the new entry |
| ins_ppn | input | PA_W-12 | Physical page number of the new entry |
| ins_size | input | 3 | Page size code |
| ins_rd_lvl | input | 2 | Privilege needed to read |
| ins_wr_lvl | input | 2 | Privilege needed to write |
| ins_ex_lvl | input | 2 | Privilege needed to execute |
| purge | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation allowed |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Matching entry denies the access |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_paddr | output | PA_W | Physical address on a hit |

## Verification
The bench builds the block with ENTRIES = 4 and 32-bit addresses. With only four slots, five inserts are enough to wrap the replacement pointer and evict the oldest page, so the round-robin order and the purge pointer reset can be seen at the ports in a few cycles. The 32-bit widths leave room for the 64 KB and 64 MB size codes, so the variable masking and pass-through of the low bits are tested at both small and large page sizes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int SIZE_W = 3;
    parameter int PRIV_W = 2;
    parameter int OFFS_W = 12;

    typedef enum logic [1:0] {
        ACC_READ     = 2'd0,
        ACC_WRITE    = 2'd1,
        ACC_EXEC     = 2'd2,
        ACC_EXEC_ALT = 2'd3
    } acc_e;

    typedef struct packed {
        logic [PRIV_W-1:0] rd;
        logic [PRIV_W-1:0] wr;
        logic [PRIV_W-1:0] ex;
    } rights_t;
endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp
    import tlb_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic              ent_valid,
    input  logic [VPN_W-1:0]  ent_vpn,
    input  logic [SIZE_W-1:0] ent_size,
    input  logic [VPN_W-1:0]  req_vpn,
    output logic              match
);
    logic [VPN_W-1:0] keep;

    always_comb begin
        for (int i = 0; i < VPN_W; i++) begin
            keep[i] = (i >= 2 * int'(ent_size));
        end
        match = ent_valid && (((ent_vpn ^ req_vpn) & keep) == '0);
    end
endmodule

// File: rtl/tlb_hit_merge.sv
module tlb_hit_merge
    import tlb_pkg::*;
#(
    parameter int N     = 8,
    parameter int PPN_W = 20
) (
    input  logic [N-1:0]             match,
    input  logic [N-1:0][PPN_W-1:0]  ent_ppn,
    input  logic [N-1:0][SIZE_W-1:0] ent_size,
    input  rights_t [N-1:0]          ent_rights,
    output logic                     any,
    output logic                     multi,
    output logic [PPN_W-1:0]         sel_ppn,
    output logic [SIZE_W-1:0]        sel_size,
    output rights_t                  sel_rights
);
    always_comb begin
        sel_ppn    = '0;
        sel_size   = '0;
        sel_rights = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                sel_ppn    = sel_ppn | ent_ppn[i];
                sel_size   = sel_size | ent_size[i];
                sel_rights = sel_rights | ent_rights[i];
            end
        end
        any   = |match;
        multi = ($countones(match) > 1);
    end
endmodule

// File: rtl/tlb_rights_chk.sv
module tlb_rights_chk
    import tlb_pkg::*;
(
    input  rights_t           rights,
    input  acc_e              kind,
    input  logic [PRIV_W-1:0] priv,
    output logic              allow
);
    logic [PRIV_W-1:0] need;

    always_comb begin
        unique case (kind)
            ACC_READ:  need = rights.rd;
            ACC_WRITE: need = rights.wr;
            default:   need = rights.ex;
        endcase
        allow = (priv <= need);
    end
endmodule

// File: rtl/vp_tlb.sv
module vp_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [1:0]        lk_kind,
    input  logic [1:0]        lk_priv,
    input  logic              ins_valid,
    input  logic [VA_W-13:0]  ins_vpn,
    input  logic [PA_W-13:0]  ins_ppn,
    input  logic [2:0]        ins_size,
    input  logic [1:0]        ins_rd_lvl,
    input  logic [1:0]        ins_wr_lvl,
    input  logic [1:0]        ins_ex_lvl,
    input  logic              purge,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic              rsp_multi,
    output logic [PA_W-1:0]   rsp_paddr
);
    localparam int VPN_W = VA_W - OFFS_W;
    localparam int PPN_W = PA_W - OFFS_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [SIZE_W-1:0] size;
        rights_t           rights;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] tab;
        logic [IDX_W-1:0]   ptr;
        logic               rv;
        logic               hit;
        logic               miss;
        logic               fault;
        logic               multi;
        logic [PA_W-1:0]    pa;
    } state_t;

    state_t s_q, s_d;

    logic [VPN_W-1:0]                req_vpn;
    logic [ENTRIES-1:0]              match;
    logic [ENTRIES-1:0][PPN_W-1:0]   ent_ppn;
    logic [ENTRIES-1:0][SIZE_W-1:0]  ent_size;
    rights_t [ENTRIES-1:0]           ent_rights;
    logic                            any_hit, multi_hit, allow;
    logic [PPN_W-1:0]                sel_ppn, page_out;
    logic [SIZE_W-1:0]               sel_size;
    rights_t                         sel_rights;

    assign req_vpn = lk_vaddr[VA_W-1:OFFS_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_tag_cmp #(.VPN_W(VPN_W)) i_cmp (
            .ent_valid (s_q.tab[g].valid),
            .ent_vpn   (s_q.tab[g].vpn),
            .ent_size  (s_q.tab[g].size),
            .req_vpn   (req_vpn),
            .match     (match[g])
        );
        assign ent_ppn[g]    = s_q.tab[g].ppn;
        assign ent_size[g]   = s_q.tab[g].size;
        assign ent_rights[g] = s_q.tab[g].rights;
    end

    tlb_hit_merge #(.N(ENTRIES), .PPN_W(PPN_W)) i_merge (
        .match      (match),
        .ent_ppn    (ent_ppn),
        .ent_size   (ent_size),
        .ent_rights (ent_rights),
        .any        (any_hit),
        .multi      (multi_hit),
        .sel_ppn    (sel_ppn),
        .sel_size   (sel_size),
        .sel_rights (sel_rights)
    );

    tlb_rights_chk i_rights (
        .rights (sel_rights),
        .kind   (acc_e'(lk_kind)),
        .priv   (lk_priv),
        .allow  (allow)
    );

    // Upper page bits from the entry, low bits pass through per page size
    always_comb begin
        for (int i = 0; i < PPN_W; i++) begin
            if (i >= 2 * int'(sel_size)) begin
                page_out[i] = sel_ppn[i];
            end else if (i < VPN_W) begin
                page_out[i] = req_vpn[i];
            end else begin
                page_out[i] = 1'b0;
            end
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.rv    = lk_valid;
        s_d.hit   = 1'b0;
        s_d.miss  = 1'b0;
        s_d.fault = 1'b0;
        s_d.multi = 1'b0;
        s_d.pa    = '0;
        if (lk_valid) begin
            if (multi_hit) begin
                s_d.multi = 1'b1;
            end else if (!any_hit) begin
                s_d.miss = 1'b1;
            end else if (allow) begin
                s_d.hit = 1'b1;
                s_d.pa  = {page_out, lk_vaddr[OFFS_W-1:0]};
            end else begin
                s_d.fault = 1'b1;
            end
        end
        if (purge) begin
            for (int e = 0; e < ENTRIES; e++) begin
                s_d.tab[e].valid = 1'b0;
            end
            s_d.ptr = '0;
        end else if (ins_valid) begin
            s_d.tab[s_q.ptr].valid     = 1'b1;
            s_d.tab[s_q.ptr].vpn       = ins_vpn;
            s_d.tab[s_q.ptr].ppn       = ins_ppn;
            s_d.tab[s_q.ptr].size      = ins_size;
            s_d.tab[s_q.ptr].rights.rd = ins_rd_lvl;
            s_d.tab[s_q.ptr].rights.wr = ins_wr_lvl;
            s_d.tab[s_q.ptr].rights.ex = ins_ex_lvl;
            s_d.ptr = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rv;
    assign rsp_hit   = s_q.hit;
    assign rsp_miss  = s_q.miss;
    assign rsp_fault = s_q.fault;
    assign rsp_multi = s_q.multi;
    assign rsp_paddr = s_q.pa;

    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault, rsp_multi}) == 1));
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault && !rsp_multi);
    p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[OFFS_W-1:0] == $past(lk_vaddr[OFFS_W-1:0])));
    p_no_addr_unless_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_paddr == '0);
    p_purge_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        purge ##1 lk_valid |=> rsp_miss);
    p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !purge && s_q.ptr == LAST) |=> s_q.ptr == '0);
endmodule

// File: tb/test_vp_tlb.sv
`timescale 1ns/1ps
module test_vp_tlb;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic [1:0]  lk_priv = '0;
    logic        ins_valid = 1'b0;
    logic [19:0] ins_vpn = '0;
    logic [19:0] ins_ppn = '0;
    logic [2:0]  ins_size = '0;
    logic [1:0]  ins_rd_lvl = '0, ins_wr_lvl = '0, ins_ex_lvl = '0;
    logic        purge = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_multi;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    vp_tlb #(.ENTRIES(N), .VA_W(32), .PA_W(32)) i_vp_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind), .lk_priv(lk_priv),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_size(ins_size),
        .ins_rd_lvl(ins_rd_lvl), .ins_wr_lvl(ins_wr_lvl), .ins_ex_lvl(ins_ex_lvl),
        .purge(purge),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_multi(rsp_multi), .rsp_paddr(rsp_paddr)
    );

    // outcome codes: 0 hit, 1 miss, 2 fault, 3 multi, 4 idle
    task automatic check_resp(input string req, input int outc, input logic [31:0] pa);
        logic [36:0] act, exp;
        act = {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_multi, rsp_paddr};
        exp = {outc != 4, outc == 0, outc == 1, outc == 2, outc == 3,
               (outc == 0) ? pa : 32'h0};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_insert(input logic [19:0] vpn, input logic [19:0] ppn,
                             input logic [2:0] sz, input logic [1:0] rd,
                             input logic [1:0] wr, input logic [1:0] ex);
        @(negedge clk);
        ins_valid = 1'b1; ins_vpn = vpn; ins_ppn = ppn; ins_size = sz;
        ins_rd_lvl = rd; ins_wr_lvl = wr; ins_ex_lvl = ex;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] va, input logic [1:0] kind,
                             input logic [1:0] priv);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind; lk_priv = priv;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic do_purge();
        @(negedge clk);
        purge = 1'b1;
        @(negedge clk);
        purge = 1'b0;
    endtask

    task automatic t_reset();
        check_resp("R1 reset outputs", 4, 0);
        do_lookup(32'h1234_5678, 2'd0, 2'd0);
        check_resp("R1 empty table miss", 1, 0);
        @(negedge clk);
        check_resp("R2 idle cycle quiet", 4, 0);
    endtask

    task automatic t_sizes();
        do_purge();
        do_insert(20'h12345, 20'hABCDE, 3'd0, 2'd3, 2'd3, 2'd3);
        do_lookup(32'h1234_5678, 2'd0, 2'd3);
        check_resp("R4 4KB translate", 0, 32'hABCD_E678);
        do_lookup(32'h1234_6678, 2'd0, 2'd3);
        check_resp("R3 neighbour page miss", 1, 0);
        do_insert(20'h40000, 20'h80000, 3'd7, 2'd3, 2'd3, 2'd3);
        do_lookup(32'h43AB_CDEF, 2'd1, 2'd3);
        check_resp("R4 64MB translate", 0, 32'h83AB_CDEF);
        do_insert(20'h00010, 20'h00500, 3'd2, 2'd3, 2'd3, 2'd3);
        do_lookup(32'h0001_F123, 2'd2, 2'd3);
        check_resp("R4 64KB translate", 0, 32'h0050_F123);
        do_lookup(32'h0002_0123, 2'd2, 2'd3);
        check_resp("R3 outside 64KB page miss", 1, 0);
    endtask

    task automatic t_rights();
        do_purge();
        do_insert(20'h22222, 20'h33333, 3'd0, 2'd3, 2'd0, 2'd1);
        do_lookup(32'h2222_2010, 2'd0, 2'd3);
        check_resp("R5 read allowed priv3", 0, 32'h3333_3010);
        do_lookup(32'h2222_2010, 2'd1, 2'd3);
        check_resp("R6 write denied priv3", 2, 0);
        do_lookup(32'h2222_2010, 2'd1, 2'd0);
        check_resp("R6 write allowed priv0", 0, 32'h3333_3010);
        do_lookup(32'h2222_2020, 2'd2, 2'd1);
        check_resp("R6 exec allowed at equal level", 0, 32'h3333_3020);
        do_lookup(32'h2222_2020, 2'd2, 2'd2);
        check_resp("R6 exec denied priv2", 2, 0);
        do_lookup(32'h2222_2030, 2'd3, 2'd2);
        check_resp("R5 kind3 as exec denied", 2, 0);
        do_lookup(32'h2222_2030, 2'd3, 2'd1);
        check_resp("R5 kind3 as exec allowed", 0, 32'h3333_3030);
    endtask

    task automatic t_multi();
        do_purge();
        do_insert(20'h12345, 20'h00001, 3'd0, 2'd3, 2'd3, 2'd3);
        do_insert(20'h12344, 20'h00008, 3'd1, 2'd3, 2'd3, 2'd3);
        do_lookup(32'h1234_5000, 2'd0, 2'd0);
        check_resp("R7 overlapping entries", 3, 0);
        do_lookup(32'h1234_6000, 2'd0, 2'd0);
        check_resp("R4 16KB single match", 0, 32'h0000_A000);
    endtask

    task automatic t_replace();
        do_purge();
        for (int k = 0; k < N + 1; k++) begin
            do_insert(20'h50000 + 20'(k), 20'h60000 + 20'(k), 3'd0, 2'd3, 2'd3, 2'd3);
        end
        do_lookup(32'h5000_0004, 2'd0, 2'd0);
        check_resp("R8 oldest slot evicted", 1, 0);
        do_lookup(32'h5000_1004, 2'd0, 2'd0);
        check_resp("R8 second entry kept", 0, 32'h6000_1004);
        do_lookup(32'h5000_4004, 2'd0, 2'd0);
        check_resp("R8 wrapped insert present", 0, 32'h6000_4004);
        // same-cycle insert and lookup
        do_purge();
        @(negedge clk);
        ins_valid = 1'b1; ins_vpn = 20'h77777; ins_ppn = 20'h11111; ins_size = 3'd0;
        ins_rd_lvl = 2'd3; ins_wr_lvl = 2'd3; ins_ex_lvl = 2'd3;
        lk_valid = 1'b1; lk_vaddr = 32'h7777_7ABC; lk_kind = 2'd0; lk_priv = 2'd0;
        @(negedge clk);
        ins_valid = 1'b0; lk_valid = 1'b0;
        check_resp("R8 same-cycle lookup sees old table", 1, 0);
        do_lookup(32'h7777_7ABC, 2'd0, 2'd0);
        check_resp("R8 insert visible next cycle", 0, 32'h1111_1ABC);
    endtask

    task automatic t_purge();
        do_purge();
        do_insert(20'h0AAAA, 20'h0BBBB, 3'd0, 2'd3, 2'd3, 2'd3);
        do_purge();
        do_lookup(32'h0AAA_A000, 2'd0, 2'd0);
        check_resp("R9 purge clears entry", 1, 0);
        @(negedge clk);
        purge = 1'b1; ins_valid = 1'b1; ins_vpn = 20'h0CCCC; ins_ppn = 20'h0DDDD;
        ins_size = 3'd0;
        @(negedge clk);
        purge = 1'b0; ins_valid = 1'b0;
        do_lookup(32'h0CCC_C000, 2'd0, 2'd0);
        check_resp("R9 insert during purge ignored", 1, 0);
        // pointer back at slot 0: after N+1 inserts the first one is gone
        do_insert(20'h01000, 20'h02000, 3'd0, 2'd3, 2'd3, 2'd3);
        do_purge();
        for (int k = 0; k < N + 1; k++) begin
            do_insert(20'h03000 + 20'(k), 20'h04000 + 20'(k), 3'd0, 2'd3, 2'd3, 2'd3);
        end
        do_lookup(32'h0300_0000, 2'd0, 2'd0);
        check_resp("R9 pointer reset by purge", 1, 0);
        do_lookup(32'h0300_1000, 2'd0, 2'd0);
        check_resp("R9 slot1 entry kept", 0, 32'h0400_1000);
    endtask

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sizes();
        t_rights();
        t_multi();
        t_replace();
        t_purge();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule